// File: doc/BRIEF.md
# Indexed store address generator

This block turns one decoded store-word operation of a small 16-bit coprocessor into a single memory write and, for the self-updating forms, an index register write-back. The decode stage presents the addressing form, the base, index and source operand values, the index and source register numbers and a 5-bit immediate, all qualified by `start`. The block captures them when it is idle and computes the effective address, the store data and the updated index. It then holds one write request on the memory port until `mem_ready` accepts it.

The four addressing forms, selected by `mode`, are: 0 = base plus zero-extended immediate, 1 = base plus index, 2 = base plus index with index increment by 2 afterwards, 3 = index decremented by 2 first, then base plus that value. All sums wrap modulo 2^16. Forms 2 and 3 return the new index to the register file in the same cycle that the memory accepts the write. No condition flags are produced.

Top module: `stw_agu`

## Requirements
- R1: With `mode`=0 the write address is `base` plus `offs` zero-extended to 16 bits, the data is `src`, and `wb_en` never asserts.
- R2: With `mode`=1 the write address is `base`+`index`, the data is `src`, and `wb_en` never asserts.
- R3: With `mode`=2 the write address is `base`+`index`, and on acceptance `wb_data` is `index`+2 and `wb_sel` equals `idx_sel`.
- R4: With `mode`=3 the write address is `base`+`index`-2, and on acceptance `wb_data` is `index`-2 and `wb_sel` equals `idx_sel`.
- R5: All address and index arithmetic wraps modulo 2^16.
- R6: For `mode` 1 to 3 with `idx_sel` equal to `src_sel`, the stored data is the `index` value before any update, even if `src` differs, and the write-back still happens in forms 2 and 3.
- R7: `mem_wr` rises in the cycle after a request is accepted. It stays high with an unchanged address and data until `mem_ready` is sampled high, and it is low in the following cycle. This pattern is the same for all four forms.
- R8: `wb_en` and `done` are high only in the cycle where `mem_wr` and `mem_ready` are both high. `wb_en` is high then only for forms 2 and 3.
- R9: When `idx_sel` is 0 in form 2 or 3, `wb_en` stays low.
- R10: While a write is pending, `ready_o` is low and `start` is ignored. Operands that change after acceptance do not affect the pending write.
- R11: After reset, `mem_wr`, `wb_en` and `done` are low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, taken when `ready_o` is high |
| ready_o | output | 1 | Block is idle and can take a request |
| mode | input | 2 | Addressing form 0..3 |
| base | input | 16 | Base register value |
| index | input | 16 | Index register value |
| src | input | 16 | Source register value |
| idx_sel | input | 3 | Index register number |
| src_sel | input | 3 | Source register number |
| offs | input | 5 | Unsigned immediate offset |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | 16 | Write address |
| mem_data | output | 16 | Write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | Write accepted this cycle |
| wb_en | output | 1 | Index write-back enable |
| wb_sel | output | 3 | Index register number to write |
| wb_data | output | 16 | Updated index value |

## Verification
The memory acceptance and the index write-back fall in the same cycle, and that cycle can be pushed arbitrarily late by the memory. The bench holds `mem_ready` low for zero to two cycles per operation. It checks that `wb_en` stays low and the request stays stable while stalled, then raises `mem_ready` and judges `wb_en`, `wb_sel` and `wb_data` combinationally in that same cycle. During a stall it also offers a second `start` with different operands and confirms that no second write appears.

// File: rtl/stw_agu.sv
module stw_agu #(
  parameter int W    = 16,
  parameter int OFFW = 5,
  parameter int RNW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           ready_o,
  input  logic [1:0]     mode,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   index,
  input  logic [W-1:0]   src,
  input  logic [RNW-1:0] idx_sel,
  input  logic [RNW-1:0] src_sel,
  input  logic [OFFW-1:0] offs,
  output logic           mem_wr,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_data,
  input  logic           mem_ready,
  output logic           done,
  output logic           wb_en,
  output logic [RNW-1:0] wb_sel,
  output logic [W-1:0]   wb_data
);

  localparam logic [1:0]   M_OFF  = 2'd0;
  localparam logic [1:0]   M_DEC  = 2'd3;
  localparam logic [W-1:0] STEP   = W'(2);

  logic           pend;
  logic           upd_q;
  logic [W-1:0]   addr_q, data_q, wbv_q;
  logic [RNW-1:0] sel_q;

  wire           accept  = start && !pend;
  wire [W-1:0]   off_ext = {{(W-OFFW){1'b0}}, offs};
  wire [W-1:0]   sum     = base + ((mode == M_OFF) ? off_ext : index);
  wire [W-1:0]   eff     = (mode == M_DEC) ? sum - STEP : sum;
  wire [W-1:0]   idx_nxt = mode[0] ? index - STEP : index + STEP;
  wire           same    = (mode != M_OFF) && (idx_sel == src_sel);
  wire [W-1:0]   wdata   = same ? index : src;
  wire           upd     = mode[1] && (idx_sel != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      upd_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      wbv_q  <= '0;
      sel_q  <= '0;
    end else if (accept) begin
      pend   <= 1'b1;
      upd_q  <= upd;
      addr_q <= eff;
      data_q <= wdata;
      wbv_q  <= idx_nxt;
      sel_q  <= idx_sel;
    end else if (pend && mem_ready) begin
      pend   <= 1'b0;
    end
  end

  assign ready_o  = !pend;
  assign mem_wr   = pend;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign done     = pend && mem_ready;
  assign wb_en    = done && upd_q;
  assign wb_sel   = sel_q;
  assign wb_data  = wbv_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data)));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> !mem_wr);

  // R7
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready_o) |=> mem_wr);

  // R8
  wb_with_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mem_wr && mem_ready && done));

  // R9
  wb_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sel != '0));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && mem_wr));

endmodule

// File: tb/stw_agu_tb_top.sv
`timescale 1ns/1ps
module stw_agu_tb_top;
  logic clk = 0, rst_n = 0, start = 0, mem_ready = 0;
  logic [1:0] mode = 0;
  logic [15:0] base = 0, index = 0, src = 0;
  logic [2:0] idx_sel = 0, src_sel = 0;
  logic [4:0] offs = 0;
  logic ready_o, mem_wr, done, wb_en;
  logic [15:0] mem_addr, mem_data, wb_data;
  logic [2:0] wb_sel;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  stw_agu dut_i (.clk(clk), .rst_n(rst_n), .start(start), .ready_o(ready_o),
    .mode(mode), .base(base), .index(index), .src(src), .idx_sel(idx_sel),
    .src_sel(src_sel), .offs(offs), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .done(done), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_data(wb_data));

  typedef struct packed {
    logic [1:0] m; logic [15:0] b, x, s; logic [2:0] is, ss; logic [4:0] o;
    logic [15:0] ea, ed; logic ew; logic [15:0] ev;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h1000, 16'h7777, 16'hABCD, 3'd1, 3'd2, 5'h1F, 16'h101F, 16'hABCD, 1'b0, 16'h0},
    '{2'd0, 16'hFFF0, 16'h0000, 16'h1111, 3'd1, 3'd1, 5'h1F, 16'h000F, 16'h1111, 1'b0, 16'h0},
    '{2'd1, 16'h2000, 16'h0345, 16'h2222, 3'd1, 3'd2, 5'h03, 16'h2345, 16'h2222, 1'b0, 16'h0},
    '{2'd2, 16'h3000, 16'h0010, 16'h5555, 3'd3, 3'd4, 5'h00, 16'h3010, 16'h5555, 1'b1, 16'h0012},
    '{2'd3, 16'h3000, 16'h0010, 16'h6666, 3'd3, 3'd4, 5'h00, 16'h300E, 16'h6666, 1'b1, 16'h000E},
    '{2'd2, 16'hFFFF, 16'h0001, 16'h1234, 3'd7, 3'd1, 5'h00, 16'h0000, 16'h1234, 1'b1, 16'h0003},
    '{2'd2, 16'h0000, 16'hFFFF, 16'h4321, 3'd2, 3'd1, 5'h00, 16'hFFFF, 16'h4321, 1'b1, 16'h0001},
    '{2'd3, 16'h0000, 16'h0000, 16'h0F0F, 3'd4, 3'd1, 5'h00, 16'hFFFE, 16'h0F0F, 1'b1, 16'hFFFE},
    '{2'd3, 16'h1000, 16'h0040, 16'h9999, 3'd5, 3'd5, 5'h00, 16'h103E, 16'h0040, 1'b1, 16'h003E},
    '{2'd2, 16'h0000, 16'h0100, 16'h7777, 3'd6, 3'd6, 5'h00, 16'h0100, 16'h0100, 1'b1, 16'h0102},
    '{2'd3, 16'h0010, 16'h0000, 16'h3333, 3'd0, 3'd1, 5'h00, 16'h000E, 16'h3333, 1'b0, 16'h0},
    '{2'd1, 16'h0010, 16'h0004, 16'h8888, 3'd2, 3'd2, 5'h00, 16'h0014, 16'h0004, 1'b0, 16'h0}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R5";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R5";  7: return "R5";
      8: return "R6";  9: return "R6";  10: return "R9"; default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input string tag, input int stall, input bit poke);
    @(negedge clk);
    mode = v.m; base = v.b; index = v.x; src = v.s;
    idx_sel = v.is; src_sel = v.ss; offs = v.o; start = 1; mem_ready = 0;
    @(negedge clk);
    start = 0; base = ~v.b; index = ~v.x; src = ~v.s; idx_sel = ~v.is;
    #1;
    chk(mem_wr === 1'b1, "R7", "mem_wr after accept", 16'(mem_wr), 16'h1);
    chk(ready_o === 1'b0, "R10", "ready_o while pending", 16'(ready_o), 16'h0);
    chk(mem_addr === v.ea, tag, "mem_addr", mem_addr, v.ea);
    chk(mem_data === v.ed, tag, "mem_data", mem_data, v.ed);
    for (int k = 0; k < stall; k++) begin
      chk(wb_en === 1'b0 && done === 1'b0, "R8", "wb_en/done during stall", 16'(wb_en), 16'h0);
      if (poke) begin start = 1; mode = 2'd0; offs = 5'h05; end
      @(negedge clk);
      start = 0;
      #1;
      chk(mem_wr === 1'b1 && mem_addr === v.ea && mem_data === v.ed, "R10",
          "request held during stall", mem_addr, v.ea);
    end
    mem_ready = 1;
    #1;
    chk(done === 1'b1, "R8", "done on accept", 16'(done), 16'h1);
    chk(wb_en === v.ew, tag, "wb_en", 16'(wb_en), 16'(v.ew));
    if (v.ew) begin
      chk(wb_sel === v.is, tag, "wb_sel", 16'(wb_sel), 16'(v.is));
      chk(wb_data === v.ev, tag, "wb_data", wb_data, v.ev);
    end
    @(negedge clk);
    mem_ready = 0;
    #1;
    chk(mem_wr === 1'b0, "R7", "mem_wr low after accept", 16'(mem_wr), 16'h0);
    chk(ready_o === 1'b1, "R7", "ready_o after accept", 16'(ready_o), 16'h1);
  endtask

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(mem_wr === 1'b0, "R11", "mem_wr in reset", 16'(mem_wr), 16'h0);
    chk(wb_en === 1'b0 && done === 1'b0, "R11", "wb_en/done in reset", 16'(wb_en), 16'h0);
    chk(ready_o === 1'b1, "R11", "ready_o in reset", 16'(ready_o), 16'h1);
    rst_n = 1;
    for (int i = 0; i < NV; i++) run_op(VEC[i], tag_of(i), i % 3, 1'b0);
    // R10: start offered while stalled must not launch a second write
    run_op(VEC[3], "R10", 2, 1'b1);
    #1;
    chk(mem_wr === 1'b0, "R10", "no second write from ignored start", 16'(mem_wr), 16'h0);
    // R1 offset mode ignores the register numbers being equal
    run_op('{2'd0, 16'h0040, 16'hAAAA, 16'h5A5A, 3'd3, 3'd3, 5'h01, 16'h0041, 16'h5A5A, 1'b0, 16'h0},
           "R1", 1, 1'b0);
    // R2 / R9 indexed mode through register 0: no write-back
    run_op('{2'd1, 16'h0100, 16'h0000, 16'hC3C3, 3'd0, 3'd1, 5'h00, 16'h0100, 16'hC3C3, 1'b0, 16'h0},
           "R2", 0, 1'b0);
    // R9 post-increment through register 0
    run_op('{2'd2, 16'h0100, 16'h0000, 16'hC3C3, 3'd0, 3'd1, 5'h00, 16'h0100, 16'hC3C3, 1'b0, 16'h0},
           "R9", 1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule